// File: doc/BRIEF.md
# SPI Serial Memory Slave Front-End

This block is the serial edge of a byte-wide memory device. It watches the chip-select, serial-clock, serial-data-in and active-low pause pins through synchronizers on a faster system clock. It assembles incoming bits into bytes, most significant bit first, and hands each finished byte to a downstream command decoder with a one-cycle strobe. In the other direction it accepts a byte from the decoder at every byte boundary and shifts it out on the serial output, driving a separate tristate enable that is active only while the device is selected and not paused.

Both supported clock polarities work without configuration: idle-low (mode 0) and idle-high (mode 3). Input bits are taken on rising serial-clock edges and output bits change on falling edges. A falling chip select opens a fresh frame and clears the bit position, so a frame cut short by deselection leaves nothing behind. The pause input freezes a transfer mid-byte: while paused, clock and data transitions are ignored and the output is released. After release the transfer resumes at the exact bit where it stopped.

Top module: `spi_mem_frontend`

## Requirements
- R1: While reset is high and on the first cycle after, `miso_oe_o`, `rx_valid_o` and `frame_start_o` are 0 and `rx_byte_o` is 0.
- R2: When chip select is high (deselected), `miso_oe_o` is 0 within a few system clocks.
- R3: Input bits are sampled on rising serial-clock edges, most significant bit first; after the eighth rising edge of a byte, `rx_byte_o` holds the byte (first bit sampled in bit 7).
- R4: `rx_valid_o` pulses high for exactly one system clock per completed byte.
- R5: `frame_start_o` pulses for one system clock on each chip-select falling edge.
- R6: In modes 0 and 3, the byte on `tx_byte_i` is loaded at the first falling serial-clock edge after a byte boundary and appears on `miso_o` bit 7 first, one bit per falling edge; in mode 3 the falling edge before the first rising edge of a frame moves nothing.
- R7: A chip-select falling edge resets the bit position, so bits of an aborted partial frame produce no strobe and do not enter the next byte.
- R8: With the device selected and the serial clock low, a low pause input enters the paused state: `miso_oe_o` goes to 0 and serial-clock and serial-data transitions are ignored.
- R9: A pause request made while the serial clock is high takes no effect until the serial clock is low.
- R10: The pause ends when the pause input is high while the serial clock is low; `miso_oe_o` returns to 1 and the byte completes from the bit where it stopped.
- R11: Deselecting during a pause ends it; the next frame with the pause input high starts from bit 7 and behaves normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous |
| mosi_i | input | 1 | Serial data in, asynchronous |
| hold_n_i | input | 1 | Pause request, active low, asynchronous |
| tx_byte_i | input | DATA_W | Byte from the decoder to send next |
| miso_o | output | 1 | Serial data out value |
| miso_oe_o | output | 1 | Tristate enable for the serial output |
| rx_byte_o | output | DATA_W | Last completed received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a completed byte |
| frame_start_o | output | 1 | One-cycle strobe at chip-select falling edge |

## Verification
The hardest case to reach from the ports is a pause requested while the serial clock is high in the middle of a byte. That request must be deferred, take effect only on the next low clock, and then survive clock and data toggling without moving the bit position. The stimulus drives a bit with the clock raised, drops the pause input before lowering the clock, checks the output enable at each step, toggles garbage on the clock and data while paused, then releases with the clock low and finishes the byte. The byte must arrive intact with a single strobe.

// File: rtl/spi_front_pkg.sv
package spi_front_pkg;

  // Synchronized view of the asynchronous pins.
  typedef struct packed {
    logic cs_n;
    logic sck;
    logic mosi;
    logic hold_n;
  } pins_t;

  localparam int PINS_W = $bits(pins_t);

  // Inactive levels: deselected, clock low, pause released.
  localparam pins_t PINS_IDLE = '{cs_n: 1'b1, sck: 1'b0, mosi: 1'b0, hold_n: 1'b1};

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/spi_hold_ctl.sv
module spi_hold_ctl (
  input  logic clk,
  input  logic rst,
  input  logic selected_i,
  input  logic sck_i,
  input  logic hold_n_i,
  output logic held_o
);

  // The pause state only changes while the serial clock is low;
  // a request seen with the clock high waits. Deselection clears it.
  always_ff @(posedge clk) begin
    if (rst || !selected_i) held_o <= 1'b0;
    else if (!sck_i)        held_o <= !hold_n_i;
  end

endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_fall_i,
  input  logic              active_i,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              mosi_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              frame_start_o,
  output logic              miso_o,
  output logic [CNT_W-1:0]  bit_cnt_o
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] rx_sr;
  logic [DATA_W-1:0] tx_sr;
  logic [DATA_W-1:0] rx_next;
  logic              seen_rise;

  assign rx_next = {rx_sr[DATA_W-2:0], mosi_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sr         <= '0;
      tx_sr         <= '0;
      rx_byte_o     <= '0;
      rx_valid_o    <= 1'b0;
      frame_start_o <= 1'b0;
      bit_cnt_o     <= '0;
      seen_rise     <= 1'b0;
    end else begin
      rx_valid_o    <= 1'b0;
      frame_start_o <= 1'b0;
      if (cs_fall_i) begin
        bit_cnt_o     <= '0;
        seen_rise     <= 1'b0;
        tx_sr         <= '0;
        frame_start_o <= 1'b1;
      end else if (active_i) begin
        if (sck_rise_i) begin
          rx_sr     <= rx_next;
          seen_rise <= 1'b1;
          if (bit_cnt_o == LAST_BIT) begin
            rx_byte_o  <= rx_next;
            rx_valid_o <= 1'b1;
            bit_cnt_o  <= '0;
          end else begin
            bit_cnt_o <= bit_cnt_o + 1'b1;
          end
        end else if (sck_fall_i && seen_rise) begin
          // Falling edge right after a byte boundary loads the reply byte.
          if (bit_cnt_o == '0) tx_sr <= tx_byte_i;
          else                 tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign miso_o = tx_sr[DATA_W-1];

endmodule

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_i,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              hold_n_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              frame_start_o
);
  import spi_front_pkg::*;

  localparam int CNT_W = $clog2(DATA_W);

  pins_t            pins_raw;
  pins_t            pins_s;
  logic             sck_q;
  logic             cs_n_q;
  logic             held;
  logic             selected;
  logic             active;
  logic             sck_rise;
  logic             sck_fall;
  logic             cs_fall;
  logic [CNT_W-1:0] bit_cnt;

  assign pins_raw = '{cs_n: cs_n_i, sck: sck_i, mosi: mosi_i, hold_n: hold_n_i};

  spi_sync #(
    .W       (PINS_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PINS_IDLE)
  ) i_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pins_raw),
    .q_o (pins_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q  <= 1'b0;
      cs_n_q <= 1'b1;
    end else begin
      sck_q  <= pins_s.sck;
      cs_n_q <= pins_s.cs_n;
    end
  end

  assign selected = !pins_s.cs_n;
  assign cs_fall  = cs_n_q && !pins_s.cs_n;
  assign sck_rise = pins_s.sck && !sck_q;
  assign sck_fall = !pins_s.sck && sck_q;
  assign active   = selected && !held;

  spi_hold_ctl i_hold (
    .clk        (clk),
    .rst        (rst),
    .selected_i (selected),
    .sck_i      (pins_s.sck),
    .hold_n_i   (pins_s.hold_n),
    .held_o     (held)
  );

  spi_shift_eng #(
    .DATA_W (DATA_W)
  ) i_eng (
    .clk           (clk),
    .rst           (rst),
    .cs_fall_i     (cs_fall),
    .active_i      (active),
    .sck_rise_i    (sck_rise),
    .sck_fall_i    (sck_fall),
    .mosi_i        (pins_s.mosi),
    .tx_byte_i     (tx_byte_i),
    .rx_byte_o     (rx_byte_o),
    .rx_valid_o    (rx_valid_o),
    .frame_start_o (frame_start_o),
    .miso_o        (miso_o),
    .bit_cnt_o     (bit_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) miso_oe_o <= 1'b0;
    else     miso_oe_o <= active;
  end

endmodule

// File: rtl/spi_front_chk.sv
module spi_front_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_n_s,
  input logic             sck_s,
  input logic             held,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             miso_oe_o,
  input logic             rx_valid_o,
  input logic             frame_start_o
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!miso_oe_o && !rx_valid_o && !frame_start_o));

  a_r2_deselect_release: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> !miso_oe_o);

  a_r4_single_strobe: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o);

  a_r7_frame_clears_count: assert property (@(posedge clk) disable iff (rst)
    frame_start_o |-> (bit_cnt == '0));

  a_r8_paused_no_byte: assert property (@(posedge clk) disable iff (rst)
    held |=> !rx_valid_o);

  a_r8_paused_released_out: assert property (@(posedge clk) disable iff (rst)
    held |=> !miso_oe_o);

  a_r9_no_pause_clock_high: assert property (@(posedge clk) disable iff (rst)
    (!held && sck_s) |=> !held);

  a_r10_release_clock_low: assert property (@(posedge clk) disable iff (rst)
    $fell(held) |-> (!$past(sck_s) || $past(cs_n_s)));

endmodule

bind spi_mem_frontend spi_front_chk #(
  .CNT_W (CNT_W)
) i_chk (
  .clk           (clk),
  .rst           (rst),
  .cs_n_s        (pins_s.cs_n),
  .sck_s         (pins_s.sck),
  .held          (held),
  .bit_cnt       (bit_cnt),
  .miso_oe_o     (miso_oe_o),
  .rx_valid_o    (rx_valid_o),
  .frame_start_o (frame_start_o)
);

// File: tb/test_spi_mem_frontend.sv
module test_spi_mem_frontend;

  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1;
  logic [7:0] tx_byte = 8'h00;
  logic       miso, miso_oe, rx_valid, frame_start;
  logic [7:0] rx_byte;

  int checks = 0, errors = 0, vcnt = 0, fcnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_mem_frontend i_spi_mem_frontend (
    .clk(clk), .rst(rst), .cs_n_i(cs_n), .sck_i(sck), .mosi_i(mosi),
    .hold_n_i(hold_n), .tx_byte_i(tx_byte), .miso_o(miso), .miso_oe_o(miso_oe),
    .rx_byte_o(rx_byte), .rx_valid_o(rx_valid), .frame_start_o(frame_start)
  );

  always @(posedge clk) begin
    if (rx_valid)    vcnt <= vcnt + 1;
    if (frame_start) fcnt <= fcnt + 1;
  end

  // {mode3, command byte, reply byte}
  localparam logic [16:0] VEC [4] = '{
    {1'b0, 8'hA5, 8'h3C},
    {1'b1, 8'h96, 8'hF0},
    {1'b0, 8'h01, 8'h80},
    {1'b1, 8'hFF, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_h();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic spi_bit(input logic m3, input logic b, output logic so);
    if (m3) begin
      sck = 1'b0; mosi = b; wait_h(); so = miso; sck = 1'b1; wait_h();
    end else begin
      mosi = b; wait_h(); so = miso; sck = 1'b1; wait_h(); sck = 1'b0;
    end
  endtask

  task automatic spi_byte(input logic m3, input logic [7:0] d, output logic [7:0] q);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      spi_bit(m3, d[i], b);
      q[i] = b;
    end
  endtask

  task automatic select(input logic m3);
    int f0;
    sck = m3; wait_h();
    f0 = fcnt;
    cs_n = 1'b0; wait_h();
    chk("R5 frame start count", fcnt, f0 + 1);
  endtask

  task automatic deselect();
    cs_n = 1'b1; wait_h();
    chk("R2 oe low when deselected", miso_oe, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    logic       b;
    int         v0;

    repeat (5) @(negedge clk);
    chk("R1 oe in reset", miso_oe, 1'b0);
    chk("R1 valid in reset", rx_valid, 1'b0);
    chk("R1 frame strobe in reset", frame_start, 1'b0);
    chk("R1 rx byte in reset", rx_byte, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 oe after reset", miso_oe, 1'b0);
    wait_h();

    // Table walk: command byte in, reply byte out, both modes.
    for (int k = 0; k < 4; k++) begin
      tx_byte = VEC[k][7:0];
      select(VEC[k][16]);
      chk("R10 oe while selected", miso_oe, 1'b1);
      v0 = vcnt;
      spi_byte(VEC[k][16], VEC[k][15:8], q);
      wait_h();
      chk("R3 received byte", rx_byte, VEC[k][15:8]);
      chk("R4 one strobe per byte", vcnt, v0 + 1);
      spi_byte(VEC[k][16], 8'h00, q);
      chk("R6 reply bits", q, VEC[k][7:0]);
      deselect();
    end

    // R7: aborted partial frame, then a clean byte.
    select(1'b0);
    v0 = vcnt;
    for (int i = 0; i < 3; i++) spi_bit(1'b0, 1'b1, b);
    deselect();
    chk("R7 no strobe from partial frame", vcnt, v0);
    select(1'b0);
    spi_byte(1'b0, 8'h81, q);
    wait_h();
    chk("R7 byte after abort", rx_byte, 8'h81);
    chk("R7 strobe count after abort", vcnt, v0 + 1);
    deselect();

    // R8 and R10: pause with clock low mid-byte, garbage while paused.
    select(1'b0);
    v0 = vcnt;
    spi_bit(1'b0, 1'b1, b);
    spi_bit(1'b0, 1'b0, b);
    spi_bit(1'b0, 1'b1, b);
    hold_n = 1'b0; wait_h();
    chk("R8 oe released while paused", miso_oe, 1'b0);
    for (int i = 0; i < 3; i++) begin
      mosi = ~mosi; sck = 1'b1; wait_h();
      sck = 1'b0; wait_h();
    end
    chk("R8 no strobe while paused", vcnt, v0);
    hold_n = 1'b1; wait_h();
    chk("R10 oe back after release", miso_oe, 1'b1);
    for (int i = 4; i >= 0; i--) spi_bit(1'b0, 8'hA5 >> i, b);
    wait_h();
    chk("R10 byte resumed intact", rx_byte, 8'hA5);
    chk("R10 single strobe after resume", vcnt, v0 + 1);
    deselect();

    // R9: pause requested with clock high is deferred.
    select(1'b0);
    v0 = vcnt;
    spi_bit(1'b0, 1'b0, b);
    spi_bit(1'b0, 1'b0, b);
    mosi = 1'b1; wait_h(); sck = 1'b1;
    hold_n = 1'b0; wait_h();
    chk("R9 pause deferred while clock high", miso_oe, 1'b1);
    sck = 1'b0; wait_h();
    chk("R9 pause taken once clock low", miso_oe, 1'b0);
    sck = 1'b1; mosi = 1'b0; wait_h();
    sck = 1'b0; wait_h();
    hold_n = 1'b1; wait_h();
    for (int i = 4; i >= 0; i--) spi_bit(1'b0, 8'h3C >> i, b);
    wait_h();
    chk("R9 byte intact around deferred pause", rx_byte, 8'h3C);
    chk("R9 strobe count", vcnt, v0 + 1);
    deselect();

    // R11: deselect while paused, next frame starts clean.
    select(1'b0);
    v0 = vcnt;
    spi_bit(1'b0, 1'b1, b);
    spi_bit(1'b0, 1'b1, b);
    hold_n = 1'b0; wait_h();
    chk("R11 paused before deselect", miso_oe, 1'b0);
    deselect();
    hold_n = 1'b1; wait_h();
    select(1'b0);
    chk("R11 oe on in new frame", miso_oe, 1'b1);
    spi_byte(1'b0, 8'h5A, q);
    wait_h();
    chk("R11 byte in new frame", rx_byte, 8'h5A);
    chk("R11 strobe count", vcnt, v0 + 1);
    deselect();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule